// File: doc/BRIEF.md
# Channel FIFO Controller with Flow and Interrupt Triggers

This block keeps the two data queues of a single 16C550-compatible serial channel: a receive queue, filled by the deserializer and drained by the host, and a transmit queue, filled by the host and drained by the serializer. Each received byte carries a flag for malformed serial data (framing, parity or break), and that flag stays with its byte through the queue. The host reads the fill levels directly. It programs the receive and flow-control thresholds as preset fractions of the queue or as exact byte counts.

From the fill levels the block derives three interrupt sources: line status, receive data and transmit threshold. It encodes the highest-priority active source into an identity byte. It also drives the request-to-send line from the receive fill level, and stops the serializer while clear-to-send is deasserted. Configuration and level readback use a small 3-bit addressed register port. Host reads of the receive queue and writes to the transmit queue use dedicated strobes.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: Each queue holds up to 32 entries and returns them in arrival order. The receive error flag (`rx_push_err`) appears on `rx_pop_err` together with its own byte. A pop from an empty queue is ignored.
- R2: Register address 5 reads the receive fill count (0..32). Address 6 reads the transmit free-space count (32 minus fill, 0..32). Both change on the clock edge that accepts a push or pop.
- R3: A push into a full queue is dropped and sets a sticky overrun flag: bit 0 at address 7 for receive, bit 1 for transmit. A push is accepted only when the fill before the edge is below 32. `ls_ack` clears both flags.
- R4: `rx_flush` or `tx_flush` empties its queue on the next edge and has priority over a push or pop in the same cycle. A transmit flush of a non-empty queue sets the transmit-threshold condition.
- R5: The control register is at address 0: bit0 FIFO enable, bit1 auto-RTS, bit2 auto-CTS, bit3 exact triggers, bits5:4 receive preset, bits7:6 flow preset. Preset codes 00/01/10/11 select 1/8/16/28 bytes. With bit3 set, address 3 (receive) and address 2 (flow) give the triggers, clamped to 1..32. With FIFO enable clear, the receive trigger is 1.
- R6: Address 1 is the interrupt enable: bit0 receive data, bit1 transmit, bit2 line status. The receive-data source is active while the receive fill is at or above the receive trigger. It clears only when pops bring the fill below that trigger.
- R7: The transmit source is set when a serializer pop brings the transmit fill to the value at address 4, or to zero. It clears on an accepted host push or on `tx_ack`. If a clear and a set fall in the same cycle, the set wins. It is set after reset.
- R8: `irq_id` bit0 is 0 when any enabled source is active. Bits3:1 carry 011 (line status), 010 (receive data) or 001 (transmit), taking the highest active in that order, and 000 when none is active. Bits7:6 both equal FIFO enable and bits5:4 are 0. `irq` is the inverse of bit0.
- R9: With auto-RTS on, `rts_n` goes high one edge after the receive fill exceeds the flow trigger. It goes low one edge after the fill drops below the trigger, and holds while the fill equals the trigger. With auto-RTS off, `rts_n` is 0.
- R10: `tx_ready` is high when the transmit queue is non-empty and auto-CTS is off or `cts_n` is 0. A `tx_pop` while `tx_ready` is low changes nothing.
- R11: The line-status source is active when either overrun flag is set, or when the receive queue is non-empty and its head byte carries the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_push_data | input | 8 | Received byte |
| rx_push_err | input | 1 | Received byte was malformed |
| rx_pop | input | 1 | Host takes the head byte |
| rx_pop_data | output | 8 | Head byte of the receive queue |
| rx_pop_err | output | 1 | Error flag of the head byte |
| rx_flush | input | 1 | Empty the receive queue |
| tx_push | input | 1 | Host writes a byte to send |
| tx_push_data | input | 8 | Byte to send |
| tx_pop | input | 1 | Serializer takes the head byte |
| tx_pop_data | output | 8 | Head byte of the transmit queue |
| tx_ready | output | 1 | Serializer may start a character |
| tx_flush | input | 1 | Empty the transmit queue |
| ls_ack | input | 1 | Clear overrun flags |
| tx_ack | input | 1 | Clear the transmit interrupt source |
| irq_id | output | 8 | Interrupt identity byte |
| irq | output | 1 | Any enabled source active |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The bench drives the receive queue through fill and drain swings that cross the 8-byte interrupt trigger and the 16-byte flow trigger. It pushes into a full queue and mixes error-flagged bytes in. A design that clears the receive interrupt on any read, or releases `rts_n` at equality, shows a wrong identity byte or a wrong `rts_n` in those swings. Directed cases cover the exact-trigger hysteresis, a pop held off by clear-to-send, the transmit source rising at the threshold and dropping on a push, and identity priority when an error byte sits at the head. A wrong flag-to-byte pairing or a lost overrun shows up at the readback and identity ports.

// File: rtl/uart_fifo_pkg.sv
// Shared definitions for the channel FIFO controller: register map,
// control-field layout and interrupt identity codes.
package uart_fifo_pkg;

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_IEN    = 3'd1;
    localparam logic [2:0] ADDR_FLOWX  = 3'd2;
    localparam logic [2:0] ADDR_RXIX   = 3'd3;
    localparam logic [2:0] ADDR_TXTRIG = 3'd4;
    localparam logic [2:0] ADDR_RXLVL  = 3'd5;
    localparam logic [2:0] ADDR_TXFREE = 3'd6;
    localparam logic [2:0] ADDR_STAT   = 3'd7;

    localparam logic [2:0] CODE_LINE = 3'b011;
    localparam logic [2:0] CODE_RXD  = 3'b010;
    localparam logic [2:0] CODE_THR  = 3'b001;
    localparam logic [2:0] CODE_NONE = 3'b000;

    // Control register, MSB first.
    typedef struct packed {
        logic [1:0] flow_sel;
        logic [1:0] rx_sel;
        logic       exact;
        logic       auto_cts;
        logic       auto_rts;
        logic       fifo_en;
    } ctrl_t;

endpackage

// File: rtl/fifo_queue.sv
// Circular byte queue with show-ahead read and fill counter.
// Assumes: a push while full is dropped and reported on `drop`;
// a pop while empty is ignored; flush wins over push and pop.
module fifo_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          drop
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          push_ok, pop_ok, full, empty;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign drop    = push && full && !flush;
    assign rdata   = mem[rp];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; no reset needed on data.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    // Pointer and fill-count update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= wrap_inc(wp);
            if (pop_ok)  rp <= wrap_inc(rp);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/trig_select.sv
// Resolves a trigger level from a 2-bit preset code or an exact count.
// Presets are 1, a quarter, a half and seven eighths of DEPTH.
// Assumes DEPTH <= 255; exact values are clamped to 1..DEPTH.
module trig_select #(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [1:0]    sel,
    input  logic [7:0]    exact_val,
    input  logic          use_exact,
    input  logic          force_one,
    output logic [CW-1:0] level
);
    logic [CW-1:0] presets [4];

    // One preset per code, derived from the depth.
    for (genvar g = 0; g < 4; g++) begin : g_preset
        localparam int LV = (g == 0) ? 1 :
                            (g == 1) ? DEPTH / 4 :
                            (g == 2) ? DEPTH / 2 : (DEPTH * 7) / 8;
        assign presets[g] = CW'((LV < 1) ? 1 : LV);
    end

    // Select preset or clamped exact value.
    always_comb begin
        if (force_one)
            level = CW'(1);
        else if (!use_exact)
            level = presets[sel];
        else if (exact_val == 8'd0)
            level = CW'(1);
        else if (int'(exact_val) > DEPTH)
            level = CW'(DEPTH);
        else
            level = CW'(exact_val);
    end
endmodule

// File: rtl/irq_encode.sv
// Prioritised interrupt identity: line status over receive data over
// transmit threshold. Assumes inputs are already gated by enables.
module irq_encode
    import uart_fifo_pkg::*;
(
    input  logic       line_req,
    input  logic       rxd_req,
    input  logic       thr_req,
    input  logic       fifo_en,
    output logic [7:0] id,
    output logic       pending
);
    logic [2:0] code;

    // Pick the highest-priority active source.
    always_comb begin
        if (line_req)     code = CODE_LINE;
        else if (rxd_req) code = CODE_RXD;
        else if (thr_req) code = CODE_THR;
        else              code = CODE_NONE;
    end

    assign pending = line_req || rxd_req || thr_req;
    assign id      = {fifo_en, fifo_en, 2'b00, code, !pending};
endmodule

// File: rtl/uart_fifo_ctrl.sv
// Receive/transmit queue pair of one serial channel with readable
// levels, trigger-based interrupts, identity encoding and automatic
// RTS/CTS flow control. Assumes cts_n is already synchronised and
// DEPTH <= 255 so levels fit the 8-bit register port.
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       rx_push,
    input  logic [7:0] rx_push_data,
    input  logic       rx_push_err,
    input  logic       rx_pop,
    output logic [7:0] rx_pop_data,
    output logic       rx_pop_err,
    input  logic       rx_flush,
    input  logic       tx_push,
    input  logic [7:0] tx_push_data,
    input  logic       tx_pop,
    output logic [7:0] tx_pop_data,
    output logic       tx_ready,
    input  logic       tx_flush,
    input  logic       ls_ack,
    input  logic       tx_ack,
    output logic [7:0] irq_id,
    output logic       irq,
    input  logic       cts_n,
    output logic       rts_n
);
    ctrl_t         ctrl_q;
    logic [2:0]    ien_q;
    logic [7:0]    flow_x_q, rxi_x_q, txt_q;
    logic [CW-1:0] rx_cnt, tx_cnt, rx_trig, flow_trig;
    logic          rx_drop, tx_drop, rx_ovr, tx_ovr, thr_flag, rts_q;
    logic          tx_pop_acc, tx_push_acc, tx_fall, line_src;
    logic [8:0]    rx_head;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            ien_q    <= '0;
            flow_x_q <= '0;
            rxi_x_q  <= '0;
            txt_q    <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_CTRL:   ctrl_q   <= ctrl_t'(cfg_wdata);
                ADDR_IEN:    ien_q    <= cfg_wdata[2:0];
                ADDR_FLOWX:  flow_x_q <= cfg_wdata;
                ADDR_RXIX:   rxi_x_q  <= cfg_wdata;
                ADDR_TXTRIG: txt_q    <= cfg_wdata;
                default: ;
            endcase
        end
    end

    fifo_queue #(.W(9), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_push),
        .wdata ({rx_push_err, rx_push_data}),
        .pop   (rx_pop),
        .rdata (rx_head),
        .count (rx_cnt),
        .drop  (rx_drop)
    );
    assign rx_pop_data = rx_head[7:0];
    assign rx_pop_err  = rx_head[8];

    assign tx_ready = (tx_cnt != '0) && !(ctrl_q.auto_cts && cts_n);

    fifo_queue #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (tx_push),
        .wdata (tx_push_data),
        .pop   (tx_pop && tx_ready),
        .rdata (tx_pop_data),
        .count (tx_cnt),
        .drop  (tx_drop)
    );

    trig_select #(.DEPTH(DEPTH)) u_rx_trig (
        .sel       (ctrl_q.rx_sel),
        .exact_val (rxi_x_q),
        .use_exact (ctrl_q.exact),
        .force_one (!ctrl_q.fifo_en),
        .level     (rx_trig)
    );

    trig_select #(.DEPTH(DEPTH)) u_flow_trig (
        .sel       (ctrl_q.flow_sel),
        .exact_val (flow_x_q),
        .use_exact (ctrl_q.exact),
        .force_one (1'b0),
        .level     (flow_trig)
    );

    // Sticky overrun flags; a new drop wins over the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ovr <= 1'b0;
            tx_ovr <= 1'b0;
        end else begin
            rx_ovr <= rx_drop || (rx_ovr && !ls_ack);
            tx_ovr <= tx_drop || (tx_ovr && !ls_ack);
        end
    end

    assign tx_push_acc = tx_push && (tx_cnt != CW'(DEPTH)) && !tx_flush;
    assign tx_pop_acc  = tx_pop && tx_ready && !tx_flush && !tx_push_acc;
    assign tx_fall     = (tx_pop_acc && ((32'(tx_cnt) - 1 == 32'(txt_q)) || tx_cnt == CW'(1)))
                      || (tx_flush && tx_cnt != '0);

    // Transmit threshold source: set on falling to trigger/empty.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_flag <= 1'b1;
        else if (tx_fall)
            thr_flag <= 1'b1;
        else if (tx_push_acc || tx_ack)
            thr_flag <= 1'b0;
    end

    // Automatic request-to-send with hold at equality.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_q.auto_rts)
            rts_q <= 1'b0;
        else if (rx_cnt > flow_trig)
            rts_q <= 1'b1;
        else if (rx_cnt < flow_trig)
            rts_q <= 1'b0;
    end
    assign rts_n = rts_q;

    assign line_src = rx_ovr || tx_ovr || ((rx_cnt != '0) && rx_head[8]);

    irq_encode u_irq (
        .line_req (ien_q[2] && line_src),
        .rxd_req  (ien_q[0] && (rx_cnt >= rx_trig)),
        .thr_req  (ien_q[1] && thr_flag),
        .fifo_en  (ctrl_q.fifo_en),
        .id       (irq_id),
        .pending  (irq)
    );

    // Register readback.
    always_comb begin
        case (cfg_addr)
            ADDR_CTRL:   cfg_rdata = ctrl_q;
            ADDR_IEN:    cfg_rdata = {5'd0, ien_q};
            ADDR_FLOWX:  cfg_rdata = flow_x_q;
            ADDR_RXIX:   cfg_rdata = rxi_x_q;
            ADDR_TXTRIG: cfg_rdata = txt_q;
            ADDR_RXLVL:  cfg_rdata = 8'(rx_cnt);
            ADDR_TXFREE: cfg_rdata = 8'(CW'(DEPTH) - tx_cnt);
            default:     cfg_rdata = {6'd0, tx_ovr, rx_ovr};
        endcase
    end
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
// Property checker for uart_fifo_ctrl, bound into every instance.
module uart_fifo_ctrl_chk #(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_trig,
    input logic [CW-1:0] flow_trig,
    input logic          rx_flush,
    input logic          rx_push,
    input logic          rx_ovr,
    input logic          tx_push,
    input logic          tx_flush,
    input logic          tx_ready,
    input logic          auto_rts,
    input logic          auto_cts,
    input logic          cts_n,
    input logic          rts_n,
    input logic          rx_ien,
    input logic [7:0]    irq_id
);
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH)));

    assert_flush_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_cnt == '0));

    assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_flush && rx_cnt == CW'(DEPTH)) |=> rx_ovr);

    assert_rxirq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ien && rx_cnt >= rx_trig) |-> !irq_id[0]);

    assert_id_zero_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_id[5:4] == 2'b00);

    assert_rts_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts && rx_cnt > flow_trig) |=> rts_n);

    assert_cts_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts && cts_n) |-> !tx_ready);

    assert_cts_no_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts && cts_n && !tx_push && !tx_flush) |=> (tx_cnt == $past(tx_cnt)));
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_cnt    (rx_cnt),
    .tx_cnt    (tx_cnt),
    .rx_trig   (rx_trig),
    .flow_trig (flow_trig),
    .rx_flush  (rx_flush),
    .rx_push   (rx_push),
    .rx_ovr    (rx_ovr),
    .tx_push   (tx_push),
    .tx_flush  (tx_flush),
    .tx_ready  (tx_ready),
    .auto_rts  (ctrl_q.auto_rts),
    .auto_cts  (ctrl_q.auto_cts),
    .cts_n     (cts_n),
    .rts_n     (rts_n),
    .rx_ien    (ien_q[0]),
    .irq_id    (irq_id)
);

// File: tb/sim_uart_fifo_ctrl.sv
module sim_uart_fifo_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0; logic [2:0] cfg_addr = 0; logic [7:0] cfg_wdata = 0;
    logic [7:0] cfg_rdata;
    logic rx_push = 0, rx_push_err = 0, rx_pop = 0, rx_flush = 0;
    logic [7:0] rx_push_data = 0, rx_pop_data;
    logic rx_pop_err;
    logic tx_push = 0, tx_pop = 0, tx_flush = 0, ls_ack = 0, tx_ack = 0;
    logic [7:0] tx_push_data = 0, tx_pop_data;
    logic tx_ready, irq, rts_n, cts_n = 0;
    logic [7:0] irq_id;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_fifo_ctrl u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(); @(negedge clk); endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d; cyc(); cfg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        cfg_addr = a; #1; d = cfg_rdata;
    endtask

    task automatic rxp(input logic [7:0] d, input logic e);
        rx_push = 1; rx_push_data = d; rx_push_err = e; cyc(); rx_push = 0; rx_push_err = 0;
    endtask

    task automatic rxr(); rx_pop = 1; cyc(); rx_pop = 0; endtask

    task automatic txp(input logic [7:0] d);
        tx_push = 1; tx_push_data = d; cyc(); tx_push = 0;
    endtask

    task automatic txr(); tx_pop = 1; cyc(); tx_pop = 0; endtask

    function automatic logic [7:0] exp_id(input bit en, input bit ls, input bit rxd, input bit thr);
        logic [2:0] c;
        c = ls ? 3'b011 : rxd ? 3'b010 : thr ? 3'b001 : 3'b000;
        return {en, en, 2'b00, c, !(ls || rxd || thr)};
    endfunction

    initial begin
        logic [7:0] v;
        logic [8:0] mq[$];
        bit ovr_m, rts_m;
        void'($urandom(32'd1234));
        repeat (3) cyc();
        rst_n = 1; cyc();

        // Reset state
        rd(3'd5, v); chk("R2 reset rx level", v, 0);
        rd(3'd6, v); chk("R2 reset tx free", v, 32);
        chk("R8 reset id", irq_id, 8'h01);
        chk("R9 reset rts", rts_n, 0);
        chk("R10 reset tx_ready", tx_ready, 0);

        // FIFO on, auto-RTS, rx preset 8, flow preset 16, all enables
        wr(3'd0, 8'h97); wr(3'd1, 8'h07);
        chk("R7 thr set after reset", irq_id, 8'hC2);
        tx_ack = 1; cyc(); tx_ack = 0;
        chk("R7 tx_ack clears", irq_id, 8'hC1);

        // Random receive traffic against a queue model
        cfg_addr = 3'd5; ovr_m = 0; rts_m = 0;
        for (int i = 0; i < 600; i++) begin
            int pp = (i % 200 < 100) ? 70 : 30;
            bit p = ($urandom % 100) < pp;
            bit q = ($urandom % 100) < (100 - pp);
            bit e = ($urandom % 8) == 0;
            logic [7:0] d = 8'($urandom);
            int old;
            rx_push = p; rx_pop = q; rx_push_data = d; rx_push_err = e;
            cyc();
            old = mq.size();
            if (old > 16) rts_m = 1; else if (old < 16) rts_m = 0;
            if (q && old > 0) void'(mq.pop_front());
            if (p && old < 32) mq.push_back({e, d}); else if (p) ovr_m = 1;
            chk("R2 rx level", cfg_rdata, mq.size());
            if (mq.size() > 0)
                chk("R1 head data+err", {rx_pop_err, rx_pop_data}, mq[0]);
            chk("R11/R6/R8 id", irq_id,
                exp_id(1, ovr_m || (mq.size() > 0 && mq[0][8]), mq.size() >= 8, 0));
            chk("R9 rts", rts_n, rts_m);
        end
        rx_push = 0; rx_pop = 0; rx_push_err = 0;

        // Flush and overrun clear
        rx_flush = 1; cyc(); rx_flush = 0;
        rd(3'd5, v); chk("R4 flush level", v, 0);
        rd(3'd7, v); chk("R3 ovr sticky", v[0], ovr_m);
        for (int i = 0; i < 33; i++) rxp(8'(i), 0);
        rd(3'd7, v); chk("R3 rx overrun", v, 8'h01);
        rd(3'd5, v); chk("R3 level at full", v, 32);
        rxr(); chk("R1 first kept byte", rx_pop_data, 8'd1);
        ls_ack = 1; cyc(); ls_ack = 0;
        rd(3'd7, v); chk("R3 ls_ack clears", v, 0);
        rx_flush = 1; cyc(); rx_flush = 0; cyc();
        rxr(); rd(3'd5, v); chk("R1 pop empty ignored", v, 0);

        // Exact triggers: rx 3, flow 4
        wr(3'd3, 8'd3); wr(3'd2, 8'd4); wr(3'd0, 8'h9B);
        rxp(8'hA1, 0); rxp(8'hA2, 0);
        chk("R6 below exact trig", irq_id, 8'hC1);
        rxp(8'hA3, 0);
        chk("R5 exact rx trig", irq_id, 8'hC4);
        rxr();
        chk("R6 clears below trig", irq_id, 8'hC1);
        rxp(8'hA4, 0); rxp(8'hA5, 0); cyc();
        chk("R9 hold at equal", rts_n, 0);
        rxp(8'hA6, 0); cyc();
        chk("R9 release above", rts_n, 1);
        rxr(); cyc();
        chk("R9 hold at equal high", rts_n, 1);
        rxr(); cyc();
        chk("R9 assert below", rts_n, 0);
        rx_flush = 1; cyc(); rx_flush = 0;
        rxp(8'h55, 1);
        chk("R11 head error priority", irq_id, 8'hC6);
        chk("R1 err flag travels", rx_pop_err, 1);
        rx_flush = 1; cyc(); rx_flush = 0;

        // Transmit side: trigger 2, auto-CTS
        wr(3'd4, 8'd2); wr(3'd0, 8'h9F);
        for (int i = 0; i < 5; i++) txp(8'h10 + 8'(i));
        rd(3'd6, v); chk("R2 tx free", v, 27);
        cts_n = 1; #1; chk("R10 cts blocks", tx_ready, 0);
        txr(); rd(3'd6, v); chk("R10 pop ignored", v, 27);
        cts_n = 0; #1; chk("R10 cts allows", tx_ready, 1);
        chk("R1 tx order", tx_pop_data, 8'h10);
        txr(); txr();
        chk("R7 above trig", irq_id, 8'hC1);
        txr();
        chk("R7 at trig", irq_id, 8'hC2);
        chk("R1 tx head", tx_pop_data, 8'h13);
        txp(8'h20);
        chk("R7 push clears", irq_id, 8'hC1);
        tx_flush = 1; cyc(); tx_flush = 0;
        chk("R4 tx flush sets thr", irq_id, 8'hC2);
        rd(3'd6, v); chk("R4 tx flush free", v, 32);
        for (int i = 0; i < 33; i++) txp(8'(i));
        rd(3'd7, v); chk("R3 tx overrun", v, 8'h02);
        rd(3'd6, v); chk("R3 tx free at full", v, 0);
        ls_ack = 1; tx_ack = 1; cyc(); ls_ack = 0; tx_ack = 0;

        // FIFO disabled: trigger 1, id bits 7:6 clear, rts released
        wr(3'd0, 8'h00); cyc();
        chk("R9 auto off", rts_n, 0);
        rxp(8'h77, 0);
        chk("R5 fifo off trig one", irq_id, 8'h04);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule